// File: doc/BRIEF.md
# Dual-Edge Packet Lane Receiver and Data Beat Transmitter

This block terminates a packetised memory bus made of three lanes of unequal width: a 3-bit row lane, a 5-bit column lane and a 16-bit data lane. The bus moves a beat on each edge of its clock. Inside the chip this is modelled as one beat per cycle of a clock running at twice the bus rate, so one packet of four bus clocks arrives as eight consecutive beats. A one-cycle start pulse marks the first beat. The receiver gathers the beats of each lane into a wide word and presents the three words together with one-cycle valid strobes.

The row and column lanes carry address packets. Only their first four beats hold information: 12 bits for a row packet and 20 bits for a column packet. The data lane uses all eight beats and forms a 128-bit word. For the read direction, a transmitter breaks a 128-bit word into eight 16-bit beats and marks the first beat. Its output can drive the receiver's data lane directly.

Top module: `pbus_endpoint`

## Requirements
- R1: After synchronous reset, all three valid strobes and `tx_vld` are low and `tx_rdy` is high.
- R2: The beat on `dat_lane` in the cycle where `pkt_start` is high is beat 0, and the following cycles carry beats 1 to 7. Beat k lands in `dat_pkt[16k+15:16k]`, so beat 0 is in the least significant position.
- R3: `row_pkt` holds the first four `row_lane` beats, with beat k in bits [3k+2:3k]. Row beats 4 to 7 have no effect on it.
- R4: `col_pkt` holds the first four `col_lane` beats, with beat k in bits [5k+4:5k]. Column beats 4 to 7 have no effect on it.
- R5: `row_vld`, `col_vld` and `dat_vld` go high together for exactly one cycle, in the cycle after beat 7. The packet outputs keep their values until the next packet completes.
- R6: A `pkt_start` that arrives before beat 7 of the current packet abandons it: no strobe is raised for it, and the new start is treated as beat 0.
- R7: When no packet is being framed, lane activity without `pkt_start` raises no strobe and leaves the packet outputs unchanged.
- R8: A `pkt_start` in the cycle right after beat 7 opens a new packet, so packets can follow with no gap.
- R9: A `tx_load` accepted while `tx_rdy` is high makes `tx_lane` carry the word's eight 16-bit slices in the next eight cycles, lowest slice first. `tx_vld` is high for all eight, and `tx_first` is high only with slice 0.
- R10: `tx_rdy` is low during transmit beats 0 to 6, and a `tx_load` seen then is ignored. `tx_rdy` is high during beat 7, so a load in that cycle follows with no gap.
- R11: With `tx_lane` and `tx_first` fed to `dat_lane` and `pkt_start`, `dat_pkt` reproduces each transmitted word.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, one beat per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Marks beat 0 of a packet |
| row_lane | input | 3 | Row address lane |
| col_lane | input | 5 | Column address lane |
| dat_lane | input | 16 | Data lane |
| row_pkt | output | 12 | Assembled row packet |
| row_vld | output | 1 | Row packet strobe |
| col_pkt | output | 20 | Assembled column packet |
| col_vld | output | 1 | Column packet strobe |
| dat_pkt | output | 128 | Assembled data packet |
| dat_vld | output | 1 | Data packet strobe |
| tx_load | input | 1 | Request to send `tx_word` |
| tx_word | input | 128 | Word to transmit |
| tx_lane | output | 16 | Transmit beat |
| tx_first | output | 1 | Transmit beat 0 marker |
| tx_vld | output | 1 | Transmit beat present |
| tx_rdy | output | 1 | Transmitter accepts a load this cycle |

## Verification
The frame-length assertion assumes that every packet which completes was opened by a start pulse. It then requires exactly eight beat cycles between that pulse and the strobe, with a fresh pulse restarting the count. The transmitter assertions assume that `tx_load` is only meaningful when sampled on a rising edge. The stimulus changes every input on the falling edge. It holds `pkt_start` to single-cycle pulses, except in the deliberate restart scenario. During loopback, the start input is driven only by `tx_first`, and loads are offered during busy beats only to test that they are ignored.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int ROW_LANE_W = 3;
  localparam int COL_LANE_W = 5;
  localparam int DAT_LANE_W = 16;
  localparam int PKT_BEATS  = 8;
  localparam int ADDR_BEATS = 4;
endpackage

// File: rtl/pbus_framer.sv
module pbus_framer #(
  parameter int BEATS = pbus_pkg::PKT_BEATS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pkt_start,
  output logic                       beat_en,
  output logic [$clog2(BEATS)-1:0]   beat_idx,
  output logic                       pkt_done
);
  localparam int IDX_W = $clog2(BEATS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;

  // A start always wins: it is beat 0 of a fresh frame.
  always_comb begin
    beat_en  = pkt_start | busy_q;
    beat_idx = pkt_start ? '0 : cnt_q;
    pkt_done = busy_q & ~pkt_start & (cnt_q == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (pkt_start) begin
      cnt_q  <= IDX_W'(1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST_IDX) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/pbus_lane_asm.sv
module pbus_lane_asm #(
  parameter int LANE_W    = pbus_pkg::DAT_LANE_W,
  parameter int CAP_BEATS = pbus_pkg::PKT_BEATS,
  parameter int BEATS     = pbus_pkg::PKT_BEATS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANE_W-1:0]             lane,
  input  logic                          beat_en,
  input  logic [$clog2(BEATS)-1:0]      beat_idx,
  input  logic                          pkt_done,
  output logic [LANE_W*CAP_BEATS-1:0]   pkt,
  output logic                          pkt_vld
);
  localparam int IDX_W = $clog2(BEATS);
  localparam int PKT_W = LANE_W * CAP_BEATS;

  logic [PKT_W-1:0] slot_q;
  logic [PKT_W-1:0] slot_d;

  // One slot per captured beat; beats past CAP_BEATS match no slot.
  for (genvar g = 0; g < CAP_BEATS; g++) begin : g_slot
    always_comb begin
      if (beat_en && (beat_idx == IDX_W'(g)))
        slot_d[g*LANE_W +: LANE_W] = lane;
      else
        slot_d[g*LANE_W +: LANE_W] = slot_q[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      pkt     <= '0;
      pkt_vld <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      pkt_vld <= pkt_done;
      if (pkt_done) pkt <= slot_d;
    end
  end
endmodule

// File: rtl/pbus_beat_tx.sv
module pbus_beat_tx #(
  parameter int LANE_W = pbus_pkg::DAT_LANE_W,
  parameter int BEATS  = pbus_pkg::PKT_BEATS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tx_load,
  input  logic [LANE_W*BEATS-1:0]   tx_word,
  output logic [LANE_W-1:0]         tx_lane,
  output logic                      tx_first,
  output logic                      tx_vld,
  output logic                      tx_rdy
);
  localparam int IDX_W  = $clog2(BEATS);
  localparam int WORD_W = LANE_W * BEATS;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic [WORD_W-1:0] sh_q;
  logic [IDX_W-1:0]  rem_q;

  assign tx_rdy = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      rem_q    <= '0;
      tx_lane  <= '0;
      tx_first <= 1'b0;
      tx_vld   <= 1'b0;
    end else if (tx_load && tx_rdy) begin
      tx_lane  <= tx_word[LANE_W-1:0];
      sh_q     <= tx_word >> LANE_W;
      rem_q    <= LAST_IDX;
      tx_first <= 1'b1;
      tx_vld   <= 1'b1;
    end else if (rem_q != '0) begin
      tx_lane  <= sh_q[LANE_W-1:0];
      sh_q     <= sh_q >> LANE_W;
      rem_q    <= rem_q - IDX_W'(1);
      tx_first <= 1'b0;
    end else begin
      tx_first <= 1'b0;
      tx_vld   <= 1'b0;
    end
  end
endmodule

// File: rtl/pbus_endpoint.sv
module pbus_endpoint #(
  parameter int ROW_LANE_W = pbus_pkg::ROW_LANE_W,
  parameter int COL_LANE_W = pbus_pkg::COL_LANE_W,
  parameter int DAT_LANE_W = pbus_pkg::DAT_LANE_W,
  parameter int PKT_BEATS  = pbus_pkg::PKT_BEATS,
  parameter int ADDR_BEATS = pbus_pkg::ADDR_BEATS,
  localparam int ROW_PKT_W = ROW_LANE_W * ADDR_BEATS,
  localparam int COL_PKT_W = COL_LANE_W * ADDR_BEATS,
  localparam int DAT_PKT_W = DAT_LANE_W * PKT_BEATS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pkt_start,
  input  logic [ROW_LANE_W-1:0]  row_lane,
  input  logic [COL_LANE_W-1:0]  col_lane,
  input  logic [DAT_LANE_W-1:0]  dat_lane,
  output logic [ROW_PKT_W-1:0]   row_pkt,
  output logic                   row_vld,
  output logic [COL_PKT_W-1:0]   col_pkt,
  output logic                   col_vld,
  output logic [DAT_PKT_W-1:0]   dat_pkt,
  output logic                   dat_vld,
  input  logic                   tx_load,
  input  logic [DAT_PKT_W-1:0]   tx_word,
  output logic [DAT_LANE_W-1:0]  tx_lane,
  output logic                   tx_first,
  output logic                   tx_vld,
  output logic                   tx_rdy
);
  localparam int IDX_W = $clog2(PKT_BEATS);

  logic             beat_en;
  logic [IDX_W-1:0] beat_idx;
  logic             pkt_done;

  pbus_framer #(.BEATS(PKT_BEATS)) framer_i (
    .clk(clk), .rst(rst), .pkt_start(pkt_start),
    .beat_en(beat_en), .beat_idx(beat_idx), .pkt_done(pkt_done)
  );

  pbus_lane_asm #(.LANE_W(ROW_LANE_W), .CAP_BEATS(ADDR_BEATS), .BEATS(PKT_BEATS)) row_asm_i (
    .clk(clk), .rst(rst), .lane(row_lane), .beat_en(beat_en), .beat_idx(beat_idx),
    .pkt_done(pkt_done), .pkt(row_pkt), .pkt_vld(row_vld)
  );

  pbus_lane_asm #(.LANE_W(COL_LANE_W), .CAP_BEATS(ADDR_BEATS), .BEATS(PKT_BEATS)) col_asm_i (
    .clk(clk), .rst(rst), .lane(col_lane), .beat_en(beat_en), .beat_idx(beat_idx),
    .pkt_done(pkt_done), .pkt(col_pkt), .pkt_vld(col_vld)
  );

  pbus_lane_asm #(.LANE_W(DAT_LANE_W), .CAP_BEATS(PKT_BEATS), .BEATS(PKT_BEATS)) dat_asm_i (
    .clk(clk), .rst(rst), .lane(dat_lane), .beat_en(beat_en), .beat_idx(beat_idx),
    .pkt_done(pkt_done), .pkt(dat_pkt), .pkt_vld(dat_vld)
  );

  pbus_beat_tx #(.LANE_W(DAT_LANE_W), .BEATS(PKT_BEATS)) tx_i (
    .clk(clk), .rst(rst), .tx_load(tx_load), .tx_word(tx_word),
    .tx_lane(tx_lane), .tx_first(tx_first), .tx_vld(tx_vld), .tx_rdy(tx_rdy)
  );
endmodule

// File: rtl/pbus_endpoint_chk.sv
module pbus_endpoint_chk #(
  parameter int PKT_BEATS = pbus_pkg::PKT_BEATS
) (
  input logic clk,
  input logic rst,
  input logic pkt_start,
  input logic row_vld,
  input logic col_vld,
  input logic dat_vld,
  input logic tx_load,
  input logic tx_first,
  input logic tx_vld,
  input logic tx_rdy
);
  localparam int RUN_W = $clog2(PKT_BEATS) + 2;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  // Cycles since the most recent start pulse (0 = none seen yet).
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)                                  run_q <= '0;
    else if (pkt_start)                       run_q <= RUN_W'(1);
    else if (run_q != '0 && run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dat_vld && !row_vld && !col_vld && !tx_vld && tx_rdy));

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dat_vld |=> !dat_vld);

  // R5
  strobes_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (row_vld == dat_vld) && (col_vld == dat_vld));

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    dat_vld |-> (run_q == RUN_W'(PKT_BEATS)));

  // R9
  tx_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_load && tx_rdy) |=> (tx_first && tx_vld));

  // R9
  first_has_vld_chk: assert property (@(posedge clk) disable iff (rst)
    tx_first |-> tx_vld);

  // R10
  tx_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_load && tx_rdy) |=> !tx_rdy);

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_vld |-> tx_rdy);
endmodule

bind pbus_endpoint pbus_endpoint_chk #(.PKT_BEATS(PKT_BEATS)) chk_i (
  .clk(clk), .rst(rst), .pkt_start(pkt_start),
  .row_vld(row_vld), .col_vld(col_vld), .dat_vld(dat_vld),
  .tx_load(tx_load), .tx_first(tx_first), .tx_vld(tx_vld), .tx_rdy(tx_rdy)
);

// File: tb/pbus_endpoint_tb.sv
module pbus_endpoint_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_drv = 1'b0;
  logic [2:0]   row_lane = '0;
  logic [4:0]   col_lane = '0;
  logic [15:0]  dat_drv = '0;
  logic         loop = 1'b0;
  logic         tx_load = 1'b0;
  logic [127:0] tx_word = '0;

  logic         pkt_start;
  logic [15:0]  dat_lane;
  logic [11:0]  row_pkt;
  logic [19:0]  col_pkt;
  logic [127:0] dat_pkt;
  logic         row_vld, col_vld, dat_vld;
  logic [15:0]  tx_lane;
  logic         tx_first, tx_vld, tx_rdy;

  assign pkt_start = loop ? tx_first : start_drv;
  assign dat_lane  = loop ? tx_lane  : dat_drv;

  always #2.5 clk = ~clk;

  pbus_endpoint dut_i (
    .clk(clk), .rst(rst), .pkt_start(pkt_start),
    .row_lane(row_lane), .col_lane(col_lane), .dat_lane(dat_lane),
    .row_pkt(row_pkt), .row_vld(row_vld), .col_pkt(col_pkt), .col_vld(col_vld),
    .dat_pkt(dat_pkt), .dat_vld(dat_vld),
    .tx_load(tx_load), .tx_word(tx_word), .tx_lane(tx_lane),
    .tx_first(tx_first), .tx_vld(tx_vld), .tx_rdy(tx_rdy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int           seen_cnt;
  logic [127:0] seen_dat;
  logic         pend;
  logic [127:0] pend_w;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic sample();
    if (dat_vld) begin
      seen_cnt++;
      seen_dat = dat_pkt;
    end
  endtask

  // Drive nb beats of a frame, beat 0 with start; samples strobes first.
  task automatic drive_frame(input logic [23:0] rb, input logic [39:0] cb,
                             input logic [127:0] db, input int nb);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      sample();
      start_drv = (b == 0);
      row_lane  = rb[3*b +: 3];
      col_lane  = cb[5*b +: 5];
      dat_drv   = db[16*b +: 16];
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
      start_drv = 1'b0;
      row_lane  = 3'($urandom);
      col_lane  = 5'($urandom);
      dat_drv   = 16'($urandom);
    end
  endtask

  // Tail after beat 7: strobe cycle, then the cycle after.
  task automatic expect_packet(input string tag, input logic [23:0] rb,
                               input logic [39:0] cb, input logic [127:0] db);
    @(negedge clk);
    start_drv = 1'b0;
    chk(dat_vld && row_vld && col_vld, {tag, " R5 strobes"}, {row_vld, col_vld, dat_vld}, 3'b111);
    chk(dat_pkt == db, {tag, " R2 data"}, dat_pkt, db);
    chk(row_pkt == rb[11:0], {tag, " R3 row"}, row_pkt, rb[11:0]);
    chk(col_pkt == cb[19:0], {tag, " R4 col"}, col_pkt, cb[19:0]);
    @(negedge clk);
    chk(!dat_vld && !row_vld && !col_vld, {tag, " R5 one cycle"}, {row_vld, col_vld, dat_vld}, 3'b000);
    chk(dat_pkt == db, {tag, " R5 hold"}, dat_pkt, db);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!dat_vld && !row_vld && !col_vld, "R1 strobes", {row_vld, col_vld, dat_vld}, 0);
    chk(!tx_vld && tx_rdy, "R1 tx", {tx_vld, tx_rdy}, 2'b01);
  endtask

  task automatic t_single(input string tag, input logic [23:0] rb,
                          input logic [39:0] cb, input logic [127:0] db);
    seen_cnt = 0;
    drive_frame(rb, cb, db, 8);
    chk(seen_cnt == 0, {tag, " R5 no early strobe"}, seen_cnt, 0);
    expect_packet(tag, rb, cb, db);
  endtask

  task automatic t_restart();
    logic [127:0] d1 = {4{32'hDEAD_BEEF}};
    logic [127:0] d2 = {$urandom, $urandom, $urandom, $urandom};
    logic [23:0]  r2 = 24'($urandom);
    logic [39:0]  c2 = {8'($urandom), 32'($urandom)};
    seen_cnt = 0;
    drive_frame(24'hFFFFFF, 40'hFF_FFFF_FFFF, d1, 5);
    drive_frame(r2, c2, d2, 8);
    chk(seen_cnt == 0, "R6 partial no strobe", seen_cnt, 0);
    expect_packet("restart R6", r2, c2, d2);
  endtask

  task automatic t_idle();
    logic [127:0] held = dat_pkt;
    logic [11:0]  hrow = row_pkt;
    seen_cnt = 0;
    idle_cycles(12);
    @(negedge clk);
    sample();
    chk(seen_cnt == 0, "R7 idle no strobe", seen_cnt, 0);
    chk(dat_pkt == held && row_pkt == hrow, "R7 idle outputs held", dat_pkt, held);
  endtask

  task automatic t_b2b();
    logic [127:0] d1 = {$urandom, $urandom, $urandom, $urandom};
    logic [127:0] d2 = ~d1;
    logic [23:0]  r1 = 24'h123456, r2 = 24'hABCDEF;
    logic [39:0]  c1 = 40'h12_3456_789A, c2 = 40'hFE_DCBA_9876;
    seen_cnt = 0;
    drive_frame(r1, c1, d1, 8);
    drive_frame(r2, c2, d2, 8);
    chk(seen_cnt == 1 && seen_dat == d1, "R8 first of pair", seen_dat, d1);
    expect_packet("b2b R8", r2, c2, d2);
  endtask

  task automatic check_pending();
    if (pend) begin
      chk(dat_vld && dat_pkt == pend_w, "R11 loopback word", dat_pkt, pend_w);
      pend = 0;
    end
  endtask

  // Caller has driven tx_load for w on the preceding negedge.
  task automatic ser_loop(input logic [127:0] w, input bit intrude,
                          input bit chain, input logic [127:0] nxt);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) check_pending();
      chk(tx_vld && tx_lane == w[16*k +: 16], "R9 beat", tx_lane, w[16*k +: 16]);
      chk(tx_first == (k == 0), "R9 first marker", tx_first, (k == 0));
      chk(tx_rdy == (k == 7), "R10 ready", tx_rdy, (k == 7));
      if (intrude && k == 2) begin
        tx_load = 1'b1; tx_word = ~w;
      end else if (chain && k == 7) begin
        tx_load = 1'b1; tx_word = nxt;
      end else begin
        tx_load = 1'b0;
      end
    end
    pend = 1; pend_w = w;
    if (!chain) begin
      @(negedge clk);
      tx_load = 1'b0;
      check_pending();
      chk(!tx_vld, "R9 eight beats only", tx_vld, 0);
    end
  endtask

  task automatic t_serial();
    logic [127:0] w1 = {$urandom, $urandom, $urandom, $urandom};
    logic [127:0] w2 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [127:0] w3 = {$urandom, $urandom, $urandom, $urandom};
    loop = 1'b1;
    pend = 0;
    @(negedge clk);
    tx_load = 1'b1; tx_word = w1;
    ser_loop(w1, 1'b1, 1'b0, '0);
    @(negedge clk);
    tx_load = 1'b1; tx_word = w2;
    ser_loop(w2, 1'b0, 1'b1, w3);
    ser_loop(w3, 1'b0, 1'b0, '0);
    loop = 1'b0;
  endtask

  initial begin
    #(5ns * 100000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_single("ones", 24'hFFFFFF, 40'hFF_FFFF_FFFF, {128{1'b1}});
    t_single("alt", 24'hFFF000, 40'hFF_FFF0_0000, {8{16'hA55A}} ^ 128'h0000_FFFF_0000_0000_0000_0000_0000_1234);
    t_single("rand", 24'($urandom), {8'($urandom), 32'($urandom)}, {$urandom, $urandom, $urandom, $urandom});
    t_idle();
    t_restart();
    t_b2b();
    t_serial();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule